// File: doc/BRIEF.md
# Compact Store Address and Exception Unit

This unit sits in the memory stage of a 64-bit core that also runs a compact 16-bit instruction encoding. For a store that has already been decoded, it builds the effective address from a base value and a scaled, zero-extended immediate. It then checks the operating mode and the address alignment. The result is either a memory write request, with address, data and byte enables, or exactly one exception flag.

The store kind selects a word or a doubleword. The base can be a general register or the stack pointer. The source can be a general register or the return-address register. Together these choose the immediate width and its scale.

One registered cycle separates the inputs from the outputs. A small state register holds the outcome. `ST_IDLE` means no operation. `ST_WRITE` means a write request. `ST_TRAP_ADDR` means an address error. `ST_TRAP_RI` means a reserved-instruction trap. Every cycle, the next state is chosen from the current inputs:

- no `in_valid`: go to `ST_IDLE`
- privilege trap: go to `ST_TRAP_RI`
- else misalignment: go to `ST_TRAP_ADDR`
- otherwise: go to `ST_WRITE`

Any state can move to any other state on the next edge.

Top module: `store_agen_unit`

## Requirements
- R1: A word store with a general-register base uses `in_imm[4:0]`, scaled by 4 and zero-extended, as the offset. `in_imm[7:5]` is ignored.
- R2: A word store with the stack pointer as base uses all 8 bits of `in_imm`, scaled by 4, as the offset. This holds for a general-register source and for the return-address source.
- R3: A doubleword store scales its offset by 8. It uses `in_imm[4:0]` when the base is a general register. It also uses `in_imm[4:0]` when the stack pointer is the base and the source is a general register. It uses `in_imm[7:0]` when the stack pointer is the base and the source is the return-address register.
- R4: The address is the 64-bit sum of base and offset, wrapping without a trap. When `in_mode64`=0, the address is the sum's low 32 bits sign-extended from bit 31.
- R5: A word store whose address has bit 1 or bit 0 set raises `out_exc_addr` and issues no write.
- R6: A doubleword store whose address has any of bits 2..0 set raises `out_exc_addr` and issues no write.
- R7: A doubleword store in 32-bit mode traps with `out_exc_ri` when `in_priv` is supervisor (1) or user (2 or 3). It executes normally in 32-bit kernel mode (`in_priv`=0) and in 64-bit mode at any privilege.
- R8: The reserved-instruction trap wins over the address error. At most one exception flag is high, and `out_wr` is low whenever a flag is high.
- R9: The data bus is big-endian, and `out_be` bit i covers data bits 8i+7..8i. A doubleword store drives `out_be`=8'hFF with the full source. A word store drives the source's low 32 bits on both halves, with `out_be`=8'hF0 when address bit 2 is 0 and 8'h0F when it is 1.
- R10: Results appear exactly one clock after `in_valid` and last one cycle. A cycle with `in_valid` low, or a synchronous `rst`, leaves `out_wr`, `out_exc_addr`, `out_exc_ri` and `out_be` at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | A decoded store is presented this cycle |
| in_dword | input | 1 | 1 selects a doubleword store, 0 a word store |
| in_base_sp | input | 1 | 1 selects the stack pointer as base |
| in_src_ra | input | 1 | 1 when the source is the return-address register |
| in_imm | input | 8 | Raw immediate field |
| in_base | input | 64 | Base register value |
| in_src | input | 64 | Source register value |
| in_mode64 | input | 1 | 1 selects 64-bit mode |
| in_priv | input | 2 | 0 kernel, 1 supervisor, 2 or 3 user |
| out_wr | output | 1 | Write request |
| out_addr | output | 64 | Effective address |
| out_data | output | 64 | Write data |
| out_be | output | 8 | Byte enables |
| out_exc_addr | output | 1 | Address-error exception |
| out_exc_ri | output | 1 | Reserved-instruction exception |

## Verification
The bench sets `in_imm[7:5]` on stores that should use the narrow field. A design that picks the wrong width or scale then shifts the address by a visible amount, and the doubleword return-address case separates the two stack-pointer doubleword forms. It drives bases that carry past bit 63 and across bit 31 in 32-bit mode, so a missing sign extension or a wrong carry shows in the address. It also drives a misaligned doubleword in 32-bit user mode, where a wrong priority raises both flags or only the address error. Other tests check that word lanes and replicated data follow address bit 2, and that kernel 32-bit or 64-bit doublewords are not trapped.

// File: rtl/sxu_pkg.sv
package sxu_pkg;
    typedef enum logic [1:0] {
        ST_IDLE      = 2'd0,
        ST_WRITE     = 2'd1,
        ST_TRAP_ADDR = 2'd2,
        ST_TRAP_RI   = 2'd3
    } sxu_state_e;

    localparam logic [1:0] PRIV_KERNEL = 2'd0;
    localparam int WORD_SCALE  = 2;
    localparam int DWORD_SCALE = 3;
endpackage

// File: rtl/sxu_offset.sv
module sxu_offset #(
    parameter int XLEN     = 64,
    parameter int IMM_W    = 8,
    parameter int NARROW_W = 5
) (
    input  logic             dword,
    input  logic             base_sp,
    input  logic             src_ra,
    input  logic [IMM_W-1:0] imm,
    output logic [XLEN-1:0]  offset
);
    import sxu_pkg::*;

    logic             wide;
    logic [IMM_W-1:0] field;
    logic [XLEN-1:0]  field_ext;

    // Full field for every stack-pointer word, and for doubleword of return address.
    assign wide      = base_sp & (~dword | src_ra);
    assign field     = wide ? imm : {{(IMM_W-NARROW_W){1'b0}}, imm[NARROW_W-1:0]};
    assign field_ext = {{(XLEN-IMM_W){1'b0}}, field};
    assign offset    = dword ? (field_ext << DWORD_SCALE) : (field_ext << WORD_SCALE);
endmodule

// File: rtl/sxu_agen.sv
module sxu_agen #(
    parameter int XLEN = 64
) (
    input  logic [XLEN-1:0] base,
    input  logic [XLEN-1:0] offset,
    input  logic            mode64,
    output logic [XLEN-1:0] addr
);
    localparam int HALF_W = 32;

    logic [XLEN-1:0] sum;

    assign sum  = base + offset;
    assign addr = mode64 ? sum : {{(XLEN-HALF_W){sum[HALF_W-1]}}, sum[HALF_W-1:0]};
endmodule

// File: rtl/sxu_check.sv
module sxu_check (
    input  logic       dword,
    input  logic       mode64,
    input  logic [1:0] priv,
    input  logic [2:0] addr_low,
    output logic       trap_ri,
    output logic       trap_addr
);
    import sxu_pkg::*;

    logic misaligned;

    assign trap_ri    = dword & ~mode64 & (priv != PRIV_KERNEL);
    assign misaligned = dword ? (|addr_low) : (|addr_low[1:0]);
    assign trap_addr  = ~trap_ri & misaligned;
endmodule

// File: rtl/sxu_lanes.sv
module sxu_lanes #(
    parameter int XLEN = 64
) (
    input  logic              dword,
    input  logic              addr_hi_word,
    input  logic [XLEN-1:0]   src,
    output logic [XLEN-1:0]   data,
    output logic [XLEN/8-1:0] be
);
    localparam int BYTES  = XLEN / 8;
    localparam int HALF_W = XLEN / 2;

    assign data = dword ? src : {src[HALF_W-1:0], src[HALF_W-1:0]};

    for (genvar i = 0; i < BYTES; i++) begin : g_lane
        // Big-endian: lower addresses land on the upper lanes.
        if (i < BYTES / 2) begin : g_low
            assign be[i] = dword | addr_hi_word;
        end else begin : g_high
            assign be[i] = dword | ~addr_hi_word;
        end
    end
endmodule

// File: rtl/store_agen_unit.sv
module store_agen_unit #(
    parameter int XLEN     = 64,
    parameter int IMM_W    = 8,
    parameter int NARROW_W = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic              in_dword,
    input  logic              in_base_sp,
    input  logic              in_src_ra,
    input  logic [IMM_W-1:0]  in_imm,
    input  logic [XLEN-1:0]   in_base,
    input  logic [XLEN-1:0]   in_src,
    input  logic              in_mode64,
    input  logic [1:0]        in_priv,
    output logic              out_wr,
    output logic [XLEN-1:0]   out_addr,
    output logic [XLEN-1:0]   out_data,
    output logic [XLEN/8-1:0] out_be,
    output logic              out_exc_addr,
    output logic              out_exc_ri
);
    import sxu_pkg::*;

    localparam int BYTES = XLEN / 8;

    logic [XLEN-1:0]  offset;
    logic [XLEN-1:0]  addr_d;
    logic [XLEN-1:0]  data_d;
    logic [BYTES-1:0] be_d;
    logic             trap_ri;
    logic             trap_addr;

    sxu_state_e       state_q;
    sxu_state_e       state_d;
    logic [XLEN-1:0]  addr_q;
    logic [XLEN-1:0]  data_q;
    logic [BYTES-1:0] be_q;

    sxu_offset #(.XLEN(XLEN), .IMM_W(IMM_W), .NARROW_W(NARROW_W)) u_offset (
        .dword   (in_dword),
        .base_sp (in_base_sp),
        .src_ra  (in_src_ra),
        .imm     (in_imm),
        .offset  (offset)
    );

    sxu_agen #(.XLEN(XLEN)) u_agen (
        .base    (in_base),
        .offset  (offset),
        .mode64  (in_mode64),
        .addr    (addr_d)
    );

    sxu_check u_check (
        .dword     (in_dword),
        .mode64    (in_mode64),
        .priv      (in_priv),
        .addr_low  (addr_d[2:0]),
        .trap_ri   (trap_ri),
        .trap_addr (trap_addr)
    );

    sxu_lanes #(.XLEN(XLEN)) u_lanes (
        .dword        (in_dword),
        .addr_hi_word (addr_d[2]),
        .src          (in_src),
        .data         (data_d),
        .be           (be_d)
    );

    // Next-state choice: trap priority is encoded by order.
    always_comb begin
        if (!in_valid) begin
            state_d = ST_IDLE;
        end else if (trap_ri) begin
            state_d = ST_TRAP_RI;
        end else if (trap_addr) begin
            state_d = ST_TRAP_ADDR;
        end else begin
            state_d = ST_WRITE;
        end
    end

    // State register.
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Datapath capture.
    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q <= '0;
            data_q <= '0;
            be_q   <= '0;
        end else if (in_valid) begin
            addr_q <= addr_d;
            data_q <= data_d;
            be_q   <= be_d;
        end
    end

    // Outputs from state.
    always_comb begin
        out_wr       = 1'b0;
        out_exc_addr = 1'b0;
        out_exc_ri   = 1'b0;
        out_be       = '0;
        out_addr     = addr_q;
        out_data     = data_q;
        unique case (state_q)
            ST_IDLE: begin
            end
            ST_WRITE: begin
                out_wr = 1'b1;
                out_be = be_q;
            end
            ST_TRAP_ADDR: begin
                out_exc_addr = 1'b1;
            end
            ST_TRAP_RI: begin
                out_exc_ri = 1'b1;
            end
            default: begin
            end
        endcase
    end
endmodule

// File: rtl/sxu_checker.sv
module sxu_checker #(
    parameter int XLEN  = 64,
    parameter int IMM_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic              in_dword,
    input  logic              in_mode64,
    input  logic [1:0]        in_priv,
    input  logic              out_wr,
    input  logic [XLEN-1:0]   out_addr,
    input  logic [XLEN-1:0]   out_data,
    input  logic [XLEN/8-1:0] out_be,
    input  logic              out_exc_addr,
    input  logic              out_exc_ri
);
    localparam int HALF_W = XLEN / 2;

    AST_SINGLE_EXC: assert property (@(posedge clk) disable iff (rst) !(out_exc_addr && out_exc_ri)); // R8
    AST_NO_WR_ON_EXC: assert property (@(posedge clk) disable iff (rst) (out_exc_addr || out_exc_ri) |-> !out_wr); // R8
    AST_IDLE_NEXT: assert property (@(posedge clk) disable iff (rst) !in_valid |=> (!out_wr && !out_exc_addr && !out_exc_ri && out_be == '0)); // R10
    AST_RI_TRAP: assert property (@(posedge clk) disable iff (rst) (in_valid && in_dword && !in_mode64 && in_priv != 2'd0) |=> out_exc_ri); // R7
    AST_WORD_ALIGN: assert property (@(posedge clk) disable iff (rst) out_wr |-> out_addr[1:0] == 2'b00); // R5
    AST_DWORD_ALIGN: assert property (@(posedge clk) disable iff (rst) (out_wr && (&out_be)) |-> out_addr[2:0] == 3'b000); // R6
    AST_WORD_LANES: assert property (@(posedge clk) disable iff (rst) (out_wr && !(&out_be)) |-> ($countones(out_be) == XLEN/16 && out_data[XLEN-1:HALF_W] == out_data[HALF_W-1:0])); // R9
endmodule

bind store_agen_unit sxu_checker #(.XLEN(XLEN), .IMM_W(IMM_W)) i_sxu_checker (
    .clk          (clk),
    .rst          (rst),
    .in_valid     (in_valid),
    .in_dword     (in_dword),
    .in_mode64    (in_mode64),
    .in_priv      (in_priv),
    .out_wr       (out_wr),
    .out_addr     (out_addr),
    .out_data     (out_data),
    .out_be       (out_be),
    .out_exc_addr (out_exc_addr),
    .out_exc_ri   (out_exc_ri)
);

// File: tb/test_store_agen_unit.sv
module test_store_agen_unit;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid, in_dword, in_base_sp, in_src_ra, in_mode64;
    logic [7:0]  in_imm;
    logic [63:0] in_base, in_src;
    logic [1:0]  in_priv;
    logic        out_wr, out_exc_addr, out_exc_ri;
    logic [63:0] out_addr, out_data;
    logic [7:0]  out_be;

    int checks = 0;
    int errors = 0;

    localparam logic [63:0] SRC = 64'h1122_3344_5566_7788;
    localparam logic [63:0] REP = 64'h5566_7788_5566_7788;

    always #(CLK_PERIOD/2) clk = ~clk;

    store_agen_unit i_store_agen_unit (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_dword(in_dword),
        .in_base_sp(in_base_sp), .in_src_ra(in_src_ra), .in_imm(in_imm),
        .in_base(in_base), .in_src(in_src), .in_mode64(in_mode64), .in_priv(in_priv),
        .out_wr(out_wr), .out_addr(out_addr), .out_data(out_data), .out_be(out_be),
        .out_exc_addr(out_exc_addr), .out_exc_ri(out_exc_ri)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Flags packed as {wr, exc_addr, exc_ri, be}.
    function automatic logic [63:0] flags();
        return {53'd0, out_wr, out_exc_addr, out_exc_ri, out_be};
    endfunction

    function automatic logic [63:0] fexp(input logic wr, input logic ea, input logic ri, input logic [7:0] be);
        return {53'd0, wr, ea, ri, be};
    endfunction

    task automatic issue(input logic dw, input logic sp, input logic ra, input logic [7:0] imm,
                         input logic [63:0] base, input logic m64, input logic [1:0] priv);
        @(negedge clk);
        in_valid = 1'b1; in_dword = dw; in_base_sp = sp; in_src_ra = ra; in_imm = imm;
        in_base = base; in_src = SRC; in_mode64 = m64; in_priv = priv;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic t_reset();
        check("R10 reset flags", flags(), fexp(0, 0, 0, 8'h00));
    endtask

    task automatic t_word_gpr();
        issue(0, 0, 0, 8'hFF, 64'h1000, 1, 2);
        check("R1 word gpr addr", out_addr, 64'h107C);
        check("R9 word hi lanes", flags(), fexp(1, 0, 0, 8'h0F));
        check("R9 word data", out_data, REP);
    endtask

    task automatic t_word_sp();
        issue(0, 1, 0, 8'hFF, 64'h2000, 1, 2);
        check("R2 word sp gpr addr", out_addr, 64'h23FC);
        issue(0, 1, 1, 8'h02, 64'h2000, 1, 2);
        check("R2 word sp ra addr", out_addr, 64'h2008);
        check("R9 word lo lanes", flags(), fexp(1, 0, 0, 8'hF0));
    endtask

    task automatic t_dword();
        issue(1, 0, 0, 8'hFF, 64'h100, 1, 2);
        check("R3 dword gpr addr", out_addr, 64'h1F8);
        check("R9 dword data", out_data, SRC);
        check("R9 dword lanes", flags(), fexp(1, 0, 0, 8'hFF));
        issue(1, 1, 0, 8'hFF, 64'h100, 1, 2);
        check("R3 dword sp gpr addr", out_addr, 64'h1F8);
        issue(1, 1, 1, 8'hFF, 64'h100, 1, 2);
        check("R3 dword sp ra addr", out_addr, 64'h8F8);
    endtask

    task automatic t_wrap();
        issue(0, 0, 0, 8'h05, 64'hFFFF_FFFF_FFFF_FFF0, 1, 2);
        check("R4 64-bit wrap", out_addr, 64'h4);
        issue(0, 0, 0, 8'h01, 64'h0000_0000_7FFF_FFFC, 0, 0);
        check("R4 32-bit sign extend", out_addr, 64'hFFFF_FFFF_8000_0000);
        issue(0, 0, 0, 8'h00, 64'h1234_5678_0000_0010, 0, 2);
        check("R4 32-bit upper drop", out_addr, 64'h10);
    endtask

    task automatic t_misalign();
        issue(0, 0, 0, 8'h00, 64'h1002, 1, 0);
        check("R5 word bit1", flags(), fexp(0, 1, 0, 8'h00));
        issue(0, 0, 0, 8'h00, 64'h1001, 1, 0);
        check("R5 word bit0", flags(), fexp(0, 1, 0, 8'h00));
        issue(1, 0, 0, 8'h00, 64'h1004, 1, 0);
        check("R6 dword bit2", flags(), fexp(0, 1, 0, 8'h00));
    endtask

    task automatic t_priv();
        issue(1, 0, 0, 8'h01, 64'h1000, 0, 2);
        check("R7 32-bit user", flags(), fexp(0, 0, 1, 8'h00));
        issue(1, 0, 0, 8'h01, 64'h1000, 0, 1);
        check("R7 32-bit supervisor", flags(), fexp(0, 0, 1, 8'h00));
        issue(1, 0, 0, 8'h01, 64'h1000, 0, 0);
        check("R7 32-bit kernel", flags(), fexp(1, 0, 0, 8'hFF));
        issue(1, 0, 0, 8'h01, 64'h1000, 1, 2);
        check("R7 64-bit user", flags(), fexp(1, 0, 0, 8'hFF));
    endtask

    task automatic t_priority();
        issue(1, 0, 0, 8'h00, 64'h1003, 0, 2);
        check("R8 ri over addr", flags(), fexp(0, 0, 1, 8'h00));
    endtask

    task automatic t_idle();
        issue(0, 0, 0, 8'h00, 64'h1000, 1, 0);
        check("R10 one-cycle result", flags(), fexp(1, 0, 0, 8'hF0));
        @(negedge clk);
        check("R10 idle after", flags(), fexp(0, 0, 0, 8'h00));
    endtask

    initial begin
        rst = 1'b1; in_valid = 1'b0; in_dword = 0; in_base_sp = 0; in_src_ra = 0;
        in_imm = '0; in_base = '0; in_src = '0; in_mode64 = 1; in_priv = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_word_gpr();
        t_word_sp();
        t_dword();
        t_wrap();
        t_misalign();
        t_priv();
        t_priority();
        t_idle();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL R10 watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule